// File: doc/BRIEF.md
# Raster position interrupt generator

This block watches a horizontal and a vertical beam position, both supplied from outside, and raises two interrupts from them. The first is a one-cycle NMI pulse at the start of vertical blank, which an enable bit controls. The second is a programmable raster IRQ, a level line that can fire at a chosen column on every line, at a chosen line, or at one exact column/line point. A small register bank sits on a simple strobe bus. It holds an enable register, a 9-bit horizontal compare, a 9-bit vertical compare, and two readable status bytes that carry the NMI flag and the IRQ flag.

The NMI flag records every vertical-blank start, whether or not the NMI pulse is enabled. A read clears it, and so does the return of the vertical counter to line 0. The IRQ flag drives the IRQ line directly. Software clears it with any access to its status address. A position match counts only on the clock where the counter becomes equal to the compare value, so each position fires at most once.

Two inputs select the line limits and the blank start. One selects which of the two line-count standards applies. The other selects the extended-height picture. Two resets are provided: a power-on reset and an ordinary reset. The compare registers keep their value across the ordinary reset.

Top module: `rasterIrqGen`

## Requirements
- R1: With IRQ mode 00 (enable register bits 5:4), no IRQ is ever raised, even when both counters match their compare values.
- R2: With mode 01, the IRQ flag is set on the clock after the vertical counter becomes equal to the vertical compare value. The horizontal counter does not matter in this mode.
- R3: With mode 10, the IRQ flag is set on the clock after the horizontal counter becomes equal to the horizontal compare value, on any line.
- R4: With mode 11, the IRQ flag is set on the clock after the horizontal counter becomes equal to its compare value while the vertical counter equals the vertical compare value. A horizontal match on any other line does nothing.
- R5: A horizontal compare above 339 never matches. A vertical compare never matches above 261 when palMode is 0, or above 311 when palMode is 1.
- R6: The bus register select codes are:
  - 1: horizontal compare bits 7:0
  - 2: horizontal compare bit 8, taken from data bit 0
  - 3: vertical compare bits 7:0
  - 4: vertical compare bit 8, taken from data bit 0

  Both compare registers are 0x1FF after porN and keep their value through rstN.
- R7: irqOut stays high until a read or a write at select 6. A position that stays matched does not raise the IRQ again after it is cleared.
- R8: When enable register bit 7 is set, nmiOut pulses high for exactly one clock. The pulse comes on the clock after the vertical counter becomes 0xE1, or 0xF0 when tallMode is 1.
- R9: The NMI flag is set at that same vertical-blank start whatever the state of enable bit 7. It is cleared by a read at select 5, or when the vertical counter becomes 0.
- R10: Read data while rdEn is high depends on the select:
  - select 5: {NMI flag, openBus[6:4], version 4'h2}
  - select 6: {IRQ flag, openBus[6:0]}
  - any other select: openBus

  With rdEn low, rdData equals openBus.
- R11: Either reset (porN or rstN low) clears the enable register (select 0, write bit 7 = NMI enable, bits 5:4 = IRQ mode), the NMI flag, the IRQ flag and both outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| rstN | input | 1 | Ordinary reset, active low, asynchronous |
| hCount | input | 9 | Horizontal beam position |
| vCount | input | 9 | Vertical beam position |
| palMode | input | 1 | Selects the longer line-count standard |
| tallMode | input | 1 | Extended-height picture; moves the blank start to line 0xF0 |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regSel | input | 3 | Register select code |
| wrData | input | 8 | Write data |
| openBus | input | 8 | Value returned in unused read bits |
| rdData | output | 8 | Read data |
| nmiOut | output | 1 | One-clock NMI pulse |
| irqOut | output | 1 | IRQ level |

## Verification
Flags and interrupt outputs are registered. nmiOut, irqOut and both status flags change one clock after the edge that samples the new counter value or the bus access. Read data is combinational in the same cycle as rdEn, and a clear caused by a read is visible from the following cycle. The bench changes counters and bus strobes at falling edges. It checks registered results at the next falling edge, after exactly one rising edge. Read data is sampled a short delay after rdEn is raised, before that rising edge. Every match is preceded by a non-matching cycle, so the edge detection sees a real transition.

// File: rtl/rasterPkg.sv
package rasterPkg;
  localparam int CNT_W = 9;
  localparam int HI_W  = CNT_W - 8;

  localparam logic [2:0] SEL_ENA = 3'd0;
  localparam logic [2:0] SEL_HLO = 3'd1;
  localparam logic [2:0] SEL_HHI = 3'd2;
  localparam logic [2:0] SEL_VLO = 3'd3;
  localparam logic [2:0] SEL_VHI = 3'd4;
  localparam logic [2:0] SEL_NMI = 3'd5;
  localparam logic [2:0] SEL_IRQ = 3'd6;

  typedef struct packed {
    logic       hLoWr;
    logic       hHiWr;
    logic       vLoWr;
    logic       vHiWr;
    logic [7:0] data;
  } cmpStrobes_t;

  typedef struct packed {
    logic hRise;
    logic vRise;
    logic vMatch;
    logic vbStart;
    logic vbEnd;
  } beamEvents_t;
endpackage

// File: rtl/rasterDatapath.sv
module rasterDatapath
  import rasterPkg::*;
#(
  parameter int H_LAST        = 339,
  parameter int V_LAST_STD    = 261,
  parameter int V_LAST_EXT    = 311,
  parameter int VB_START      = 'hE1,
  parameter int VB_START_TALL = 'hF0
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             rstN,
  input  cmpStrobes_t      strb,
  input  logic [CNT_W-1:0] hCount,
  input  logic [CNT_W-1:0] vCount,
  input  logic             palMode,
  input  logic             tallMode,
  output beamEvents_t      evt
);
  localparam logic [CNT_W-1:0] H_LAST_C  = H_LAST[CNT_W-1:0];
  localparam logic [CNT_W-1:0] V_STD_C   = V_LAST_STD[CNT_W-1:0];
  localparam logic [CNT_W-1:0] V_EXT_C   = V_LAST_EXT[CNT_W-1:0];
  localparam logic [CNT_W-1:0] VB_C      = VB_START[CNT_W-1:0];
  localparam logic [CNT_W-1:0] VB_TALL_C = VB_START_TALL[CNT_W-1:0];

  logic [CNT_W-1:0] hCmp, vCmp, vMax, vbLine;
  logic hMatch, vMatch, vbMatch, topMatch;
  logic hPrev, vPrev, vbPrev, topPrev;

  // compare registers: only power-on reset touches them
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      hCmp <= '1;
      vCmp <= '1;
    end else begin
      if (strb.hLoWr) hCmp[7:0]       <= strb.data;
      if (strb.hHiWr) hCmp[CNT_W-1:8] <= strb.data[HI_W-1:0];
      if (strb.vLoWr) vCmp[7:0]       <= strb.data;
      if (strb.vHiWr) vCmp[CNT_W-1:8] <= strb.data[HI_W-1:0];
    end
  end

  always_comb begin
    vMax     = palMode ? V_EXT_C : V_STD_C;
    vbLine   = tallMode ? VB_TALL_C : VB_C;
    hMatch   = (hCount == hCmp) && (hCmp <= H_LAST_C);
    vMatch   = (vCount == vCmp) && (vCmp <= vMax);
    vbMatch  = (vCount == vbLine);
    topMatch = (vCount == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPrev   <= 1'b0;
      vPrev   <= 1'b0;
      vbPrev  <= 1'b0;
      topPrev <= 1'b0;
    end else begin
      hPrev   <= hMatch;
      vPrev   <= vMatch;
      vbPrev  <= vbMatch;
      topPrev <= topMatch;
    end
  end

  always_comb begin
    evt.hRise   = hMatch & ~hPrev;
    evt.vRise   = vMatch & ~vPrev;
    evt.vMatch  = vMatch;
    evt.vbStart = vbMatch & ~vbPrev;
    evt.vbEnd   = topMatch & ~topPrev;
  end

  AST_H_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    evt.hRise |=> !evt.hRise); // R7
  AST_H_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    evt.hRise |-> (hCount <= H_LAST_C)); // R5
  AST_V_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    evt.vRise |-> (vCount <= vMax)); // R5
endmodule

// File: rtl/rasterControl.sv
module rasterControl
  import rasterPkg::*;
#(
  parameter logic [3:0] VERSION = 4'h2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  regSel,
  input  logic [7:0]  wrData,
  input  logic [7:0]  openBus,
  input  beamEvents_t evt,
  output cmpStrobes_t strb,
  output logic [7:0]  rdData,
  output logic        nmiOut,
  output logic        irqOut
);
  logic       nmiEn, nmiFlag, irqFlag, irqEvt, irqClr, nmiClr;
  logic [1:0] irqMode;

  always_comb begin
    strb.hLoWr = wrEn && (regSel == SEL_HLO);
    strb.hHiWr = wrEn && (regSel == SEL_HHI);
    strb.vLoWr = wrEn && (regSel == SEL_VLO);
    strb.vHiWr = wrEn && (regSel == SEL_VHI);
    strb.data  = wrData;
  end

  always_comb begin
    case (irqMode)
      2'b01:   irqEvt = evt.vRise;
      2'b10:   irqEvt = evt.hRise;
      2'b11:   irqEvt = evt.hRise & evt.vMatch;
      default: irqEvt = 1'b0;
    endcase
    irqClr = (rdEn || wrEn) && (regSel == SEL_IRQ);
    nmiClr = (rdEn && (regSel == SEL_NMI)) || evt.vbEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiEn   <= 1'b0;
      irqMode <= 2'b00;
      nmiFlag <= 1'b0;
      irqFlag <= 1'b0;
      nmiOut  <= 1'b0;
    end else begin
      if (wrEn && (regSel == SEL_ENA)) begin
        nmiEn   <= wrData[7];
        irqMode <= wrData[5:4];
      end
      nmiOut <= evt.vbStart & nmiEn;
      if (evt.vbStart)  nmiFlag <= 1'b1;
      else if (nmiClr)  nmiFlag <= 1'b0;
      if (irqEvt)       irqFlag <= 1'b1;
      else if (irqClr)  irqFlag <= 1'b0;
    end
  end

  assign irqOut = irqFlag;

  always_comb begin
    rdData = openBus;
    if (rdEn) begin
      case (regSel)
        SEL_NMI: rdData = {nmiFlag, openBus[6:4], VERSION};
        SEL_IRQ: rdData = {irqFlag, openBus[6:0]};
        default: rdData = openBus;
      endcase
    end
  end

  AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> ($past(irqMode) != 2'b00)); // R1
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag); // R7
  AST_NMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    nmiOut |=> !nmiOut); // R8
  AST_NMI_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    nmiOut |-> nmiFlag); // R9
  AST_VB_END_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (evt.vbEnd && !evt.vbStart) |=> !nmiFlag); // R9
endmodule

// File: rtl/rasterIrqGen.sv
module rasterIrqGen
  import rasterPkg::*;
#(
  parameter int         H_LAST        = 339,
  parameter int         V_LAST_STD    = 261,
  parameter int         V_LAST_EXT    = 311,
  parameter int         VB_START      = 'hE1,
  parameter int         VB_START_TALL = 'hF0,
  parameter logic [3:0] VERSION       = 4'h2
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             rstN,
  input  logic [CNT_W-1:0] hCount,
  input  logic [CNT_W-1:0] vCount,
  input  logic             palMode,
  input  logic             tallMode,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [2:0]       regSel,
  input  logic [7:0]       wrData,
  input  logic [7:0]       openBus,
  output logic [7:0]       rdData,
  output logic             nmiOut,
  output logic             irqOut
);
  logic        sysRstN;
  cmpStrobes_t strb;
  beamEvents_t evt;

  assign sysRstN = porN & rstN;

  rasterDatapath #(
    .H_LAST(H_LAST), .V_LAST_STD(V_LAST_STD), .V_LAST_EXT(V_LAST_EXT),
    .VB_START(VB_START), .VB_START_TALL(VB_START_TALL)
  ) uDatapath (
    .clk(clk), .porN(porN), .rstN(sysRstN), .strb(strb),
    .hCount(hCount), .vCount(vCount), .palMode(palMode),
    .tallMode(tallMode), .evt(evt)
  );

  rasterControl #(.VERSION(VERSION)) uControl (
    .clk(clk), .rstN(sysRstN), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
    .wrData(wrData), .openBus(openBus), .evt(evt), .strb(strb),
    .rdData(rdData), .nmiOut(nmiOut), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_rasterIrqGen.sv
module tb_rasterIrqGen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [1:0] mode;
    logic       pal;
    logic [8:0] hC, vC, h0, v0, h1, v1;
    logic       exp;
    logic       rng;
  } vec_t;

  localparam logic [58:0] VECS [0:NVEC-1] = '{
    {2'b01, 1'b0, 9'd0,   9'd100, 9'd5,   9'd99,  9'd6,   9'd100, 1'b1, 1'b0},
    {2'b01, 1'b0, 9'd0,   9'd100, 9'd5,   9'd99,  9'd6,   9'd101, 1'b0, 1'b0},
    {2'b10, 1'b0, 9'd200, 9'd511, 9'd199, 9'd7,   9'd200, 9'd7,   1'b1, 1'b0},
    {2'b10, 1'b0, 9'd200, 9'd511, 9'd199, 9'd7,   9'd201, 9'd7,   1'b0, 1'b0},
    {2'b11, 1'b0, 9'd50,  9'd20,  9'd49,  9'd20,  9'd50,  9'd20,  1'b1, 1'b0},
    {2'b11, 1'b0, 9'd50,  9'd20,  9'd49,  9'd19,  9'd50,  9'd19,  1'b0, 1'b0},
    {2'b00, 1'b0, 9'd50,  9'd20,  9'd49,  9'd20,  9'd50,  9'd20,  1'b0, 1'b0},
    {2'b10, 1'b0, 9'd340, 9'd511, 9'd339, 9'd5,   9'd340, 9'd5,   1'b0, 1'b1},
    {2'b01, 1'b0, 9'd0,   9'd300, 9'd0,   9'd299, 9'd0,   9'd300, 1'b0, 1'b1},
    {2'b01, 1'b1, 9'd0,   9'd300, 9'd0,   9'd299, 9'd0,   9'd300, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic porN, rstN, palMode, tallMode, wrEn, rdEn;
  logic [8:0] hCount, vCount;
  logic [2:0] regSel;
  logic [7:0] wrData, openBus, rdData, rv;
  logic nmiOut, irqOut;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rasterIrqGen dut (
    .clk(clk), .porN(porN), .rstN(rstN), .hCount(hCount), .vCount(vCount),
    .palMode(palMode), .tallMode(tallMode), .wrEn(wrEn), .rdEn(rdEn),
    .regSel(regSel), .wrData(wrData), .openBus(openBus), .rdData(rdData),
    .nmiOut(nmiOut), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; regSel = s; wrData = d;
    @(negedge clk); wrEn = 1'b0; regSel = 3'd7;
  endtask

  task automatic readReg(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk); rdEn = 1'b1; regSel = s;
    #1 v = rdData;
    @(negedge clk); rdEn = 1'b0; regSel = 3'd7;
  endtask

  task automatic setCnt(input logic [8:0] h, input logic [8:0] v);
    @(negedge clk); hCount = h; vCount = v;
  endtask

  function automatic string modeTag(input vec_t v);
    if (v.rng) return "R5";
    case (v.mode)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    porN = 0; rstN = 0; palMode = 0; tallMode = 0; wrEn = 0; rdEn = 0;
    hCount = 0; vCount = 0; regSel = 3'd7; wrData = 0; openBus = 8'hA5;
    repeat (3) @(negedge clk);
    porN = 1; rstN = 1;
    @(negedge clk);

    // reset state and read formats
    check("R11 irqOut after reset", {15'd0, irqOut}, 16'd0);
    check("R11 nmiOut after reset", {15'd0, nmiOut}, 16'd0);
    readReg(3'd5, rv); check("R10 nmi status after reset", {8'd0, rv}, 16'h0022);
    readReg(3'd6, rv); check("R10 irq status after reset", {8'd0, rv}, 16'h0025);
    readReg(3'd7, rv); check("R10 unused select", {8'd0, rv}, 16'h00A5);
    #1 check("R10 idle bus", {8'd0, rdData}, 16'h00A5);

    // power-on compare value 0x1FF: write low byte only
    writeReg(3'd0, 8'h20);
    writeReg(3'd1, 8'h20);
    writeReg(3'd6, 8'h00);
    setCnt(9'h01F, 0); setCnt(9'h020, 0); @(negedge clk);
    check("R6 high bit kept at power-on value", {15'd0, irqOut}, 16'd0);
    setCnt(9'h11F, 0); setCnt(9'h120, 0); @(negedge clk);
    check("R6 compare 0x120 fires", {15'd0, irqOut}, 16'd1);
    setCnt(9'h121, 0); setCnt(9'h122, 0); @(negedge clk);
    check("R7 level held", {15'd0, irqOut}, 16'd1);
    readReg(3'd6, rv); check("R10 irq status flag set", {8'd0, rv}, 16'h00A5);
    @(negedge clk);
    check("R7 cleared by read", {15'd0, irqOut}, 16'd0);
    setCnt(9'h11F, 0); setCnt(9'h120, 0); @(negedge clk);
    check("R7 refire on new edge", {15'd0, irqOut}, 16'd1);
    writeReg(3'd6, 8'h00);
    repeat (3) @(negedge clk);
    check("R7 no refire while held", {15'd0, irqOut}, 16'd0);

    // retained compare across ordinary reset, enable cleared
    writeReg(3'd1, 8'hAB); writeReg(3'd2, 8'h00);
    writeReg(3'd0, 8'hA0);
    setCnt(9'h0AA, 0); setCnt(9'h0AB, 0); @(negedge clk);
    check("R3 compare 0x0AB", {15'd0, irqOut}, 16'd1);
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    check("R11 flag cleared by rstN", {15'd0, irqOut}, 16'd0);
    setCnt(9'h0AA, 0); setCnt(9'h0AB, 0); @(negedge clk);
    check("R11 mode cleared by rstN", {15'd0, irqOut}, 16'd0);
    writeReg(3'd0, 8'h20);
    setCnt(9'h0AA, 0); setCnt(9'h0AB, 0); @(negedge clk);
    check("R6 compare kept over rstN", {15'd0, irqOut}, 16'd1);
    writeReg(3'd6, 8'h00);
    setCnt(0, 0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      palMode = v.pal;
      writeReg(3'd0, {2'b00, v.mode, 4'b0000});
      writeReg(3'd1, v.hC[7:0]); writeReg(3'd2, {7'd0, v.hC[8]});
      writeReg(3'd3, v.vC[7:0]); writeReg(3'd4, {7'd0, v.vC[8]});
      setCnt(0, 0);
      writeReg(3'd6, 8'h00);
      setCnt(v.h0, v.v0); setCnt(v.h1, v.v1); @(negedge clk);
      check($sformatf("%s vector %0d", modeTag(v), i), {15'd0, irqOut}, {15'd0, v.exp});
    end
    writeReg(3'd0, 8'h00); writeReg(3'd6, 8'h00);
    palMode = 0; setCnt(0, 0);

    // NMI with enable
    writeReg(3'd0, 8'h80);
    setCnt(0, 9'hE0); setCnt(0, 9'hE1); @(negedge clk);
    check("R8 nmi pulse", {15'd0, nmiOut}, 16'd1);
    @(negedge clk);
    check("R8 nmi pulse one clock", {15'd0, nmiOut}, 16'd0);
    readReg(3'd5, rv); check("R9 nmi flag set", {8'd0, rv}, 16'h00A2);
    readReg(3'd5, rv); check("R9 nmi flag cleared by read", {8'd0, rv}, 16'h0022);

    // flag without enable
    writeReg(3'd0, 8'h00);
    setCnt(0, 9'hE0); setCnt(0, 9'hE1); @(negedge clk);
    check("R8 no pulse when disabled", {15'd0, nmiOut}, 16'd0);
    readReg(3'd5, rv); check("R9 flag set without enable", {8'd0, rv}, 16'h00A2);
    setCnt(0, 9'hE0); setCnt(0, 9'hE1); setCnt(0, 9'h105); setCnt(0, 0);
    @(negedge clk);
    readReg(3'd5, rv); check("R9 flag cleared at line 0", {8'd0, rv}, 16'h0022);

    // extended height
    tallMode = 1;
    writeReg(3'd0, 8'h80);
    setCnt(0, 9'hE0); setCnt(0, 9'hE1); @(negedge clk);
    check("R8 tall ignores 0xE1", {15'd0, nmiOut}, 16'd0);
    setCnt(0, 9'hEF); setCnt(0, 9'hF0); @(negedge clk);
    check("R8 tall fires at 0xF0", {15'd0, nmiOut}, 16'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule